// File: doc/BRIEF.md
# Dual-Width Condition Code Generator

This block derives and holds an 8-bit flag register for a 64-bit integer datapath. It watches the two operands and the result of an ALU operation that is computed elsewhere. For each flag-setting operation it produces negative, zero, overflow and carry flags twice: once for the low 32-bit view of the result and once for the full 64-bit view. Both sets are packed into one byte. The block does not compute the ALU result itself, and it does not evaluate branch conditions.

An update happens only when the strobe is high and the operation code names a valid class. The low-view carry flag acts as the carry-in of the carry-chained add and subtract classes, and it is also presented on its own output pin for the ALU. A separate direct write port loads the whole byte. When it fires in the same cycle as an update, the direct write takes priority.

Top module: `dual_cc_gen`

## Requirements
- R1: After the active-low asynchronous reset, `ccr_o` reads 0x00.
- R2: In an update, bit 3 takes result bit 31 and bit 2 is set when result bits 31:0 are all zero. Bit 7 takes result bit 63 and bit 6 is set when the full 64-bit result is zero.
- R3: For code 0 (add), bit 0 is the carry out of the sum of the operands' low 32-bit halves, and bit 4 is the carry out of the 64-bit sum. Bit 1 is set when both operands share bit 31 and result bit 31 differs from it. Bit 5 applies the same rule to bit 63.
- R4: Code 1 (add with carry) behaves like code 0, except that the register's current bit 0 is added into both carry sums.
- R5: For code 2 (subtract), bit 0 and bit 4 are the borrows out of the 32-bit and 64-bit differences (first operand minus second, taken as unsigned). Bit 1 is set when the operands differ in bit 31 and result bit 31 differs from the first operand's bit 31. Bit 5 applies the same rule to bit 63.
- R6: Code 3 (subtract with borrow) behaves like code 2, except that the register's current bit 0 is also subtracted in both borrow computations.
- R7: Code 4 (logical) clears bits 0, 1, 4 and 5, and sets the N and Z flags as in R2.
- R8: Code 5 (multiply) clears bits 0, 1, 4 and 5, and sets the N and Z flags from the result as in R2.
- R9: While `upd_i` is low, or while `op_i` is 6 or 7, the register keeps its value.
- R10: When `wr_i` is high, the register loads `wr_data_i` on the next edge, even if an update is strobed in the same cycle.
- R11: `cin_o` always equals bit 0 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Flag-update strobe |
| op_i | input | 3 | Operation class code |
| opa_i | input | DATA_W | First operand |
| opb_i | input | DATA_W | Second operand |
| res_i | input | DATA_W | ALU result |
| wr_i | input | 1 | Direct write enable |
| wr_data_i | input | 8 | Direct write value |
| ccr_o | output | 8 | Packed flag register |
| cin_o | output | 1 | Carry-in for the next operation |

## Verification
The bench builds the block with its default widths: a 64-bit datapath with a 32-bit low view. With these widths, the carry across bit 31 into bit 32 and the carry out of bit 63 can be reached with small, readable operands. The stimulus is chosen so that the two views disagree: the low word wraps to zero while the full word does not, and a sign change shows in only one of the two views. The chained add and subtract classes are run with the stored carry both clear and set, and the set value is preloaded through the direct write port.

// File: rtl/dual_cc_pkg.sv
package dual_cc_pkg;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned CC_W   = 2 * FLAG_W;

  typedef enum logic [2:0] {
    CC_ADD   = 3'd0,
    CC_ADDC  = 3'd1,
    CC_SUB   = 3'd2,
    CC_SUBC  = 3'd3,
    CC_LOGIC = 3'd4,
    CC_MUL   = 3'd5
  } cc_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

  function automatic logic op_valid(input logic [2:0] code);
    return code <= 3'd5;
  endfunction
endpackage

// File: rtl/cc_view_flags.sv
module cc_view_flags
  import dual_cc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  cc_op_e         op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   r_i,
  input  logic           cin_i,
  output nzvc_t          flags_o
);
  localparam int unsigned MSB = W - 1;

  logic         chain;
  logic [W:0]   sum_ext;
  logic [W:0]   dif_ext;

  always_comb begin
    chain   = ((op_i == CC_ADDC) || (op_i == CC_SUBC)) ? cin_i : 1'b0;
    sum_ext = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, chain};
    // borrow appears as the extension bit of the unsigned difference
    dif_ext = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, chain};

    flags_o.n = r_i[MSB];
    flags_o.z = (r_i == '0);
    flags_o.v = 1'b0;
    flags_o.c = 1'b0;
    unique case (op_i)
      CC_ADD, CC_ADDC: begin
        flags_o.c = sum_ext[W];
        flags_o.v = (a_i[MSB] == b_i[MSB]) && (r_i[MSB] != a_i[MSB]);
      end
      CC_SUB, CC_SUBC: begin
        flags_o.c = dif_ext[W];
        flags_o.v = (a_i[MSB] != b_i[MSB]) && (r_i[MSB] != a_i[MSB]);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cc_hold_reg.sv
module cc_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic [W-1:0] upd_val_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (wr_i)   q_o <= wr_val_i;
    else if (upd_i)  q_o <= upd_val_i;
  end
endmodule

// File: rtl/dual_cc_gen.sv
module dual_cc_gen
  import dual_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LO_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              wr_i,
  input  logic [CC_W-1:0]   wr_data_i,
  output logic [CC_W-1:0]   ccr_o,
  output logic              cin_o
);
  localparam int unsigned N_VIEW = 2;

  logic [CC_W-1:0] ccr_q;
  logic [CC_W-1:0] ccr_nxt;
  logic            upd_en;
  cc_op_e          op_s;
  nzvc_t           flags_v [N_VIEW];

  assign op_s   = cc_op_e'(op_i);
  assign upd_en = upd_i && op_valid(op_i);

  // view 0 is the low word, view 1 the full word
  for (genvar g = 0; g < N_VIEW; g++) begin : g_view
    localparam int unsigned VW = (g == 0) ? LO_W : DATA_W;
    cc_view_flags #(.W(VW)) i_view (
      .op_i    (op_s),
      .a_i     (opa_i[VW-1:0]),
      .b_i     (opb_i[VW-1:0]),
      .r_i     (res_i[VW-1:0]),
      .cin_i   (ccr_q[0]),
      .flags_o (flags_v[g])
    );
  end

  assign ccr_nxt = {flags_v[1], flags_v[0]};

  cc_hold_reg #(.W(CC_W)) i_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd_en),
    .upd_val_i (ccr_nxt),
    .wr_i      (wr_i),
    .wr_val_i  (wr_data_i),
    .q_o       (ccr_q)
  );

  assign ccr_o = ccr_q;
  assign cin_o = ccr_q[0];

  a_r2_sign_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en && !wr_i) |=> (ccr_o[3] == $past(res_i[LO_W-1]))
                          && (ccr_o[7] == $past(res_i[DATA_W-1])));

  a_r7_logic_clears_vc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == 3'd4 && !wr_i) |=> (ccr_o[1:0] == 2'b00 && ccr_o[5:4] == 2'b00));

  a_r8_mul_clears_vc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == 3'd5 && !wr_i) |=> (ccr_o[1:0] == 2'b00 && ccr_o[5:4] == 2'b00));

  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !wr_i) |=> $stable(ccr_o));

  a_r9_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i >= 3'd6 && !wr_i) |=> $stable(ccr_o));

  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (ccr_o == $past(wr_data_i)));
endmodule

// File: tb/test_dual_cc_gen.sv
`timescale 1ns/1ps
module test_dual_cc_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] opa = '0, opb = '0, res = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  ccr;
  logic        cin;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_state = 8'h00;
  logic [7:0] q_exp [$];
  string      q_tag [$];
  bit         done = 1'b0;

  always #5 clk = ~clk;

  dual_cc_gen i_dual_cc_gen (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .op_i(op), .opa_i(opa),
    .opb_i(opb), .res_i(res), .wr_i(wr), .wr_data_i(wdata),
    .ccr_o(ccr), .cin_o(cin)
  );

  function automatic logic [7:0] model(input logic [2:0] o, input logic [63:0] a,
                                       input logic [63:0] b, input logic [63:0] r,
                                       input logic [7:0] old);
    logic ci, c32, v32, c64, v64;
    logic [33:0] lhs32, rhs32;
    logic [65:0] lhs64, rhs64;
    ci  = (o == 3'd1 || o == 3'd3) ? old[0] : 1'b0;
    c32 = 1'b0; v32 = 1'b0; c64 = 1'b0; v64 = 1'b0;
    if (o <= 3'd1) begin
      lhs32 = {2'b00, a[31:0]} + {2'b00, b[31:0]} + {33'd0, ci};
      lhs64 = {2'b00, a} + {2'b00, b} + {65'd0, ci};
      c32 = lhs32[32]; c64 = lhs64[64];
      v32 = (a[31] == b[31]) && (r[31] != a[31]);
      v64 = (a[63] == b[63]) && (r[63] != a[63]);
    end else if (o <= 3'd3) begin
      rhs32 = {2'b00, b[31:0]} + {33'd0, ci};
      rhs64 = {2'b00, b} + {65'd0, ci};
      c32 = ({2'b00, a[31:0]} < rhs32);
      c64 = ({2'b00, a} < rhs64);
      v32 = (a[31] != b[31]) && (r[31] != a[31]);
      v64 = (a[63] != b[63]) && (r[63] != a[63]);
    end
    return {r[63], (r == 64'd0), v64, c64, r[31], (r[31:0] == 32'd0), v32, c32};
  endfunction

  task automatic drive(input logic u, input logic [2:0] o, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] r,
                       input logic w, input logic [7:0] wd, input string tag);
    @(negedge clk);
    upd = u; op = o; opa = a; opb = b; res = r; wr = w; wdata = wd;
    if (w)                    exp_state = wd;
    else if (u && o <= 3'd5)  exp_state = model(o, a, b, r, exp_state);
    @(posedge clk);
    #1;
    q_exp.push_back(exp_state);
    q_tag.push_back(tag);
    upd = 1'b0; wr = 1'b0;
  endtask

  task automatic do_op(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                       input string tag);
    logic [63:0] r;
    logic ci;
    ci = (o == 3'd1 || o == 3'd3) ? exp_state[0] : 1'b0;
    case (o)
      3'd0, 3'd1: r = a + b + {63'd0, ci};
      3'd2, 3'd3: r = a - b - {63'd0, ci};
      3'd4:       r = a & b;
      default:    r = {32'd0, a[31:0]} * {32'd0, b[31:0]};
    endcase
    drive(1'b1, o, a, b, r, 1'b0, 8'h00, tag);
  endtask

  // monitor: compares against the scoreboard away from the active edge
  always @(negedge clk) begin
    while (q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_chk++;
      if (ccr !== e) begin
        n_fail++;
        $display("FAIL %s: ccr_o actual %02h expected %02h", t, ccr, e);
      end
      n_chk++;
      if (cin !== e[0]) begin
        n_fail++;
        $display("FAIL R11 (%s): cin_o actual %0b expected %0b", t, cin, e[0]);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if (ccr !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: ccr_o actual %02h expected 00", ccr);
    end
    rst_n = 1'b1;

    // R2 views disagree
    drive(1'b1, 3'd4, 0, 0, 64'h0, 1'b0, 0, "R2 all zero");
    drive(1'b1, 3'd4, 0, 0, 64'h0000_0000_8000_0000, 1'b0, 0, "R2 low sign only");
    drive(1'b1, 3'd4, 0, 0, 64'h0000_0001_0000_0000, 1'b0, 0, "R2 low zero only");
    drive(1'b1, 3'd4, 0, 0, 64'h8000_0000_0000_0000, 1'b0, 0, "R2 high sign");
    // R3
    do_op(3'd0, 64'h0000_0000_FFFF_FFFF, 64'h1, "R3 low carry");
    do_op(3'd0, 64'h0000_0000_7FFF_FFFF, 64'h1, "R3 low overflow");
    do_op(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R3 full carry");
    do_op(3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, "R3 full overflow");
    do_op(3'd0, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, "R3 both overflow");
    // R4
    drive(1'b0, 3'd0, 0, 0, 0, 1'b1, 8'h01, "R10 preload carry");
    do_op(3'd1, 64'h0000_0000_FFFF_FFFE, 64'h1, "R4 chained carry set");
    drive(1'b0, 3'd0, 0, 0, 0, 1'b1, 8'h00, "R10 clear");
    do_op(3'd1, 64'h0000_0000_FFFF_FFFE, 64'h1, "R4 chained carry clear");
    // R5
    do_op(3'd2, 64'h1, 64'h2, "R5 borrow");
    do_op(3'd2, 64'h0000_0000_8000_0000, 64'h1, "R5 low overflow");
    do_op(3'd2, 64'h8000_0000_0000_0000, 64'h1, "R5 full overflow");
    do_op(3'd2, 64'h5, 64'h5, "R5 equal");
    // R6
    drive(1'b0, 3'd0, 0, 0, 0, 1'b1, 8'h01, "R10 preload borrow");
    do_op(3'd3, 64'h5, 64'h5, "R6 chained borrow set");
    do_op(3'd3, 64'h7, 64'h5, "R6 after borrow");
    // R7
    drive(1'b0, 3'd0, 0, 0, 0, 1'b1, 8'hFF, "R10 all ones");
    do_op(3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_8000_0000, "R7 logic clears vc");
    // R8
    drive(1'b0, 3'd0, 0, 0, 0, 1'b1, 8'hFF, "R10 all ones again");
    do_op(3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R8 mul clears vc");
    drive(1'b1, 3'd5, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'h0, 1'b0, 0, "R8 mul zero result");
    // R9
    drive(1'b0, 3'd0, 0, 0, 0, 1'b1, 8'h5A, "R10 pattern");
    drive(1'b0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 1'b0, 0, "R9 no strobe");
    drive(1'b1, 3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 1'b0, 0, "R9 code 6");
    drive(1'b1, 3'd7, 64'h1, 64'h2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0, "R9 code 7");
    // R10 write beats update
    drive(1'b1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 1'b1, 8'hA3, "R10 write wins");
    drive(1'b1, 3'd4, 0, 0, 64'h0, 1'b1, 8'h10, "R10 write wins over logic");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule